// File: doc/BRIEF.md
# Multiplexed LCD drive sequencer

This block scans a small display memory and turns it, clock by clock, into 2-bit level-select codes for four common lines and a parameterised number of segment lines. Each code picks one of four bias levels: 0 is the top rail and 3 the bottom rail. In 1/3 bias, 1 and 2 are the 2/3 and 1/3 taps. In 1/2 bias, code 1 is the midpoint. An analog ladder and output drivers outside this block turn the codes into voltages. The sequencer offers static drive and 2-, 3- and 4-way time-division multiplexing. It gates chosen bits with a slow blink, can force the whole panel to an idle state, and emits a frame marker.

Each frame gives one time slot to each active common. Each slot is split into two half-phases of equal length with opposite polarity, so the panel sees no net DC. The half-phase length is a base count scaled by a programmable power of two, so the frame rate depends on both the multiplex count and the rate field. Configuration is loaded by a write strobe. A write also restarts the scan. A reset clears the configuration, but only a reset input held low long enough counts as a reset.

Top module: `lcd_scan_seq`

## Requirements
- R1: A reset takes effect only after `rst_in_n` has been sampled low on RST_MIN (default 12) consecutive rising edges. A low pulse of RST_MIN-1 edges leaves the configuration and the scan position untouched.
- R2: A reset loads static mode, rate 0, display off and blink off. While reset is active every output code is 0. The scan restarts at position 0 on the edge that first samples `rst_in_n` high.
- R3: `cfg_mux` selects 0 = static (1 common), 1 = 2-way, 2 = 3-way, 3 = 4-way. A half-phase lasts HALF_BASE·2^`cfg_rate` clocks. A slot is two half-phases (first polarity 0, then 1), and a frame is one slot per active common. A `cfg_wr` edge loads all four fields and restarts the scan at slot 0, polarity 0, blink phase on. Outputs show scan position t on the (t+1)-th edge after a restart.
- R4: The common in the current slot drives code 3 in polarity 0 and code 0 in polarity 1. In static mode every common drives this waveform.
- R5: A lit segment drives code 0 in polarity 0 and code 3 in polarity 1. An unlit segment drives 3/0 in static and 2-way mode, and 2/1 in 3- and 4-way mode.
- R6: A common that is not in the current slot, including commons beyond the active count, drives code 1 in 2-way mode. In 3- and 4-way mode it drives 1 in polarity 0 and 2 in polarity 1.
- R7: Segment s is lit during slot k when bit s·4+k of `seg_data` is 1. A change to `seg_data` shows at the outputs one edge later.
- R8: The blink phase toggles every BLINK_FRAMES (default 4) whole frames, starting in the on phase. When `cfg_blink_en` was loaded as 1 and the phase is off, a bit whose `seg_blink` bit (same index as in R7) is 1 is shown as unlit. When `cfg_blink_en` is 0, `seg_blink` has no effect.
- R9: With the display off, every common and segment code is 0 and the data has no effect.
- R10: `frame_sync` is 1 exactly while the outputs show the first half-phase of slot 0. It runs whether or not the display is on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_in_n | input | 1 | Raw active-low reset, qualified by a low count |
| cfg_wr | input | 1 | Loads the configuration fields and restarts the scan |
| cfg_mux | input | 2 | Multiplex count select |
| cfg_rate | input | 2 | Half-phase length exponent |
| cfg_disp_on | input | 1 | Display enable |
| cfg_blink_en | input | 1 | Blink gating enable |
| seg_data | input | NSEG*4 | Display memory, 4 bits per segment |
| seg_blink | input | NSEG*4 | Blink mask, same layout as seg_data |
| com_lvl | output | 8 | Level codes for commons 0..3, 2 bits each |
| seg_lvl | output | NSEG*2 | Level codes for segments, 2 bits each |
| frame_sync | output | 1 | Frame marker aligned to common 0 |

## Verification
Every output is a registered function of the scan counters and the loaded fields. A wrong prescaler, slot or polarity value therefore appears as a wrong code or a misplaced `frame_sync` on the very next edge. It also stays misaligned from then on, so a model that checks every cycle catches it at once. A wrong blink counter shows only when the blink phase should turn. Runs are made long enough to span at least two blink turns with blink bits set. A reset qualifier that counts wrong shows as a scan that restarts after a short low pulse, or one that does not restart after a long one. Both are visible on the first checked cycle after release.

// File: rtl/lcdseq_pkg.sv
package lcdseq_pkg;

   localparam int COM_MAX = 4;

   typedef enum logic [1:0] {
      MUX_STATIC = 2'd0,
      MUX_2WAY   = 2'd1,
      MUX_3WAY   = 2'd2,
      MUX_4WAY   = 2'd3
   } mux_e;

   typedef logic [1:0] lvl_t;

   localparam lvl_t LVL_TOP  = 2'd0;
   localparam lvl_t LVL_TAPH = 2'd1;
   localparam lvl_t LVL_TAPL = 2'd2;
   localparam lvl_t LVL_BOT  = 2'd3;
   localparam lvl_t LVL_IDLE = 2'd0;

   typedef struct packed {
      mux_e       mux;
      logic [1:0] rate;
      logic       disp_on;
      logic       blink_en;
   } cfg_t;

   typedef struct packed {
      logic [1:0] slot;
      logic       pol;
      logic       blink_off;
      logic       frame_start;
   } scan_t;

   // Selected common swings rail to rail; non-selected sits on the bias taps.
   function automatic lvl_t com_code(mux_e m, logic sel, logic pol);
      lvl_t r;
      if (sel || m == MUX_STATIC) r = pol ? LVL_TOP : LVL_BOT;
      else if (m == MUX_2WAY)     r = LVL_TAPH;
      else                        r = pol ? LVL_TAPL : LVL_TAPH;
      return r;
   endfunction

   function automatic lvl_t seg_code(mux_e m, logic lit, logic pol);
      lvl_t r;
      if (lit)                                    r = pol ? LVL_BOT : LVL_TOP;
      else if (m == MUX_STATIC || m == MUX_2WAY)  r = pol ? LVL_TOP : LVL_BOT;
      else                                        r = pol ? LVL_TAPH : LVL_TAPL;
      return r;
   endfunction

endpackage

// File: rtl/lcdseq_rstq.sv
module lcdseq_rstq #(
   parameter int RST_MIN = 12
) (
   input  logic clk,
   input  logic rst_in_n,
   output logic core_rst
);
   localparam int RW = $clog2(RST_MIN + 1);

   logic [RW-1:0] low_cnt;

   always_ff @(posedge clk) begin
      if (rst_in_n)                         low_cnt <= '0;
      else if (low_cnt != RW'(RST_MIN))     low_cnt <= low_cnt + 1'b1;
   end

   assign core_rst = (low_cnt == RW'(RST_MIN));

   // R1: one high sample always clears any pending qualification
   p_short_low_r1: assert property (@(posedge clk) $past(rst_in_n) |-> !core_rst);

endmodule

// File: rtl/lcdseq_cfg.sv
module lcdseq_cfg
   import lcdseq_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic       wr,
   input  logic [1:0] mux_in,
   input  logic [1:0] rate_in,
   input  logic       on_in,
   input  logic       blink_in,
   output cfg_t       cfg
);
   always_ff @(posedge clk) begin
      if (rst) begin
         cfg.mux      <= MUX_STATIC;
         cfg.rate     <= 2'd0;
         cfg.disp_on  <= 1'b0;
         cfg.blink_en <= 1'b0;
      end else if (wr) begin
         cfg.mux      <= mux_e'(mux_in);
         cfg.rate     <= rate_in;
         cfg.disp_on  <= on_in;
         cfg.blink_en <= blink_in;
      end
   end

   // R2: a reset edge leaves the panel dark
   p_rst_dark_r2: assert property (@(posedge clk) rst |=> !cfg.disp_on);

endmodule

// File: rtl/lcdseq_timing.sv
module lcdseq_timing
   import lcdseq_pkg::*;
#(
   parameter int HALF_BASE    = 2,
   parameter int BLINK_FRAMES = 4
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       restart,
   input  mux_e       mux,
   input  logic [1:0] rate,
   output scan_t      scan
);
   localparam int PW = $clog2(HALF_BASE * 8 + 1);
   localparam int BW = (BLINK_FRAMES > 1) ? $clog2(BLINK_FRAMES) : 1;

   logic [PW-1:0] pre_cnt;
   logic [PW-1:0] half_last;
   logic [1:0]    slot;
   logic          pol;
   logic [BW-1:0] blink_cnt;
   logic          blink_off;
   logic          half_end;
   logic          slot_end;
   logic          frame_end;

   assign half_last = PW'((HALF_BASE << rate) - 1);
   assign half_end  = (pre_cnt == half_last);
   assign slot_end  = half_end && pol;
   assign frame_end = slot_end && (slot == 2'(mux));

   always_ff @(posedge clk) begin
      if (rst || restart) begin
         pre_cnt   <= '0;
         pol       <= 1'b0;
         slot      <= 2'd0;
         blink_cnt <= '0;
         blink_off <= 1'b0;
      end else begin
         pre_cnt <= half_end ? '0 : pre_cnt + 1'b1;
         if (half_end) pol <= ~pol;
         if (frame_end)     slot <= 2'd0;
         else if (slot_end) slot <= slot + 2'd1;
         if (frame_end) begin
            if (blink_cnt == BW'(BLINK_FRAMES - 1)) begin
               blink_cnt <= '0;
               blink_off <= ~blink_off;
            end else begin
               blink_cnt <= blink_cnt + 1'b1;
            end
         end
      end
   end

   assign scan.slot        = slot;
   assign scan.pol         = pol;
   assign scan.blink_off   = blink_off;
   assign scan.frame_start = (slot == 2'd0) && !pol;

   // R3: prescaler never runs past the programmed half-phase
   p_pre_bound_r3: assert property (@(posedge clk) disable iff (rst)
      pre_cnt <= half_last);
   // R3: slot stays inside the active common count
   p_slot_bound_r3: assert property (@(posedge clk) disable iff (rst)
      slot <= 2'(mux));
   // R8: blink phase only turns at the start of a frame
   p_blink_frame_r8: assert property (@(posedge clk) disable iff (rst)
      !$stable(blink_off) |-> (slot == 2'd0 && !pol && pre_cnt == '0));

endmodule

// File: rtl/lcdseq_drive.sv
module lcdseq_drive
   import lcdseq_pkg::*;
#(
   parameter int NSEG    = 8,
   parameter bit OUT_REG = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst,
   input  cfg_t                    cfg,
   input  scan_t                   scan,
   input  logic [NSEG*COM_MAX-1:0] seg_data,
   input  logic [NSEG*COM_MAX-1:0] seg_blink,
   output logic [COM_MAX*2-1:0]    com_lvl,
   output logic [NSEG*2-1:0]       seg_lvl,
   output logic                    frame_sync
);
   logic [COM_MAX*2-1:0] com_n;
   logic [NSEG*2-1:0]    seg_n;
   logic                 blink_gate;

   assign blink_gate = cfg.blink_en && scan.blink_off;

   for (genvar k = 0; k < COM_MAX; k++) begin : g_com
      assign com_n[k*2 +: 2] = cfg.disp_on
         ? com_code(cfg.mux, scan.slot == 2'(k), scan.pol) : LVL_IDLE;
   end

   for (genvar s = 0; s < NSEG; s++) begin : g_seg
      logic [COM_MAX-1:0] bits;
      logic [COM_MAX-1:0] mask;
      logic               lit;
      assign bits = seg_data [s*COM_MAX +: COM_MAX];
      assign mask = seg_blink[s*COM_MAX +: COM_MAX];
      assign lit  = bits[scan.slot] && !(blink_gate && mask[scan.slot]);
      assign seg_n[s*2 +: 2] = cfg.disp_on
         ? seg_code(cfg.mux, lit, scan.pol) : LVL_IDLE;
   end

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk) begin
         if (rst) begin
            com_lvl    <= '0;
            seg_lvl    <= '0;
            frame_sync <= 1'b0;
         end else begin
            com_lvl    <= com_n;
            seg_lvl    <= seg_n;
            frame_sync <= scan.frame_start;
         end
      end

      // R9: display off reaches every output on the next edge
      p_off_idle_r9: assert property (@(posedge clk) disable iff (rst)
         !cfg.disp_on |=> (com_lvl == '0 && seg_lvl == '0));
   end else begin : g_comb
      assign com_lvl    = com_n;
      assign seg_lvl    = seg_n;
      assign frame_sync = scan.frame_start;
   end

   // R10: the frame marker coincides with common 0 selected at polarity 0
   p_sync_com0_r10: assert property (@(posedge clk) disable iff (rst)
      frame_sync |-> (com_lvl[1:0] == LVL_BOT || com_lvl == '0));

endmodule

// File: rtl/lcd_scan_seq.sv
module lcd_scan_seq
   import lcdseq_pkg::*;
#(
   parameter int NSEG         = 8,
   parameter int HALF_BASE    = 2,
   parameter int BLINK_FRAMES = 4,
   parameter int RST_MIN      = 12,
   parameter bit OUT_REG      = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_in_n,
   input  logic                    cfg_wr,
   input  logic [1:0]              cfg_mux,
   input  logic [1:0]              cfg_rate,
   input  logic                    cfg_disp_on,
   input  logic                    cfg_blink_en,
   input  logic [NSEG*COM_MAX-1:0] seg_data,
   input  logic [NSEG*COM_MAX-1:0] seg_blink,
   output logic [COM_MAX*2-1:0]    com_lvl,
   output logic [NSEG*2-1:0]       seg_lvl,
   output logic                    frame_sync
);
   if (NSEG < 1)          begin : g_bad_nseg  $error("NSEG must be at least 1"); end
   if (HALF_BASE < 1)     begin : g_bad_half  $error("HALF_BASE must be at least 1"); end
   if (BLINK_FRAMES < 2)  begin : g_bad_blink $error("BLINK_FRAMES must be at least 2"); end
   if (RST_MIN < 2)       begin : g_bad_rst   $error("RST_MIN must be at least 2"); end

   logic  core_rst;
   cfg_t  cfg;
   scan_t scan;

   lcdseq_rstq #(.RST_MIN(RST_MIN)) u_rstq (
      .clk      (clk),
      .rst_in_n (rst_in_n),
      .core_rst (core_rst)
   );

   lcdseq_cfg u_cfg (
      .clk      (clk),
      .rst      (core_rst),
      .wr       (cfg_wr),
      .mux_in   (cfg_mux),
      .rate_in  (cfg_rate),
      .on_in    (cfg_disp_on),
      .blink_in (cfg_blink_en),
      .cfg      (cfg)
   );

   lcdseq_timing #(
      .HALF_BASE    (HALF_BASE),
      .BLINK_FRAMES (BLINK_FRAMES)
   ) u_timing (
      .clk     (clk),
      .rst     (core_rst),
      .restart (cfg_wr),
      .mux     (mux_e'(cfg.mux)),
      .rate    (cfg.rate),
      .scan    (scan)
   );

   lcdseq_drive #(
      .NSEG    (NSEG),
      .OUT_REG (OUT_REG)
   ) u_drive (
      .clk        (clk),
      .rst        (core_rst),
      .cfg        (cfg),
      .scan       (scan),
      .seg_data   (seg_data),
      .seg_blink  (seg_blink),
      .com_lvl    (com_lvl),
      .seg_lvl    (seg_lvl),
      .frame_sync (frame_sync)
   );

endmodule

// File: tb/lcd_scan_seq_test.sv
`timescale 1ns/1ps
module lcd_scan_seq_test;
   localparam int NSEG = 8;
   localparam int CM   = 4;
   localparam int HB   = 2;
   localparam int BF   = 4;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic                 rst_in_n = 1'b1;
   logic                 cfg_wr = 1'b0;
   logic [1:0]           cfg_mux = 2'd0;
   logic [1:0]           cfg_rate = 2'd0;
   logic                 cfg_disp_on = 1'b0;
   logic                 cfg_blink_en = 1'b0;
   logic [NSEG*CM-1:0]   seg_data = '0;
   logic [NSEG*CM-1:0]   seg_blink = '0;
   logic [CM*2-1:0]      com_lvl;
   logic [NSEG*2-1:0]    seg_lvl;
   logic                 frame_sync;

   lcd_scan_seq #(.NSEG(NSEG), .HALF_BASE(HB), .BLINK_FRAMES(BF), .RST_MIN(12)) uut (
      .clk(clk), .rst_in_n(rst_in_n), .cfg_wr(cfg_wr), .cfg_mux(cfg_mux),
      .cfg_rate(cfg_rate), .cfg_disp_on(cfg_disp_on), .cfg_blink_en(cfg_blink_en),
      .seg_data(seg_data), .seg_blink(seg_blink),
      .com_lvl(com_lvl), .seg_lvl(seg_lvl), .frame_sync(frame_sync)
   );

   int vectors = 0;
   int errors  = 0;
   int tcnt    = 0;
   int m_mux = 0, m_rate = 0;
   bit m_on = 0, m_blk = 0;

   // R4 R6: common codes per mode and selection
   function automatic logic [1:0] e_com(int mux, bit sel, bit p);
      if (sel || mux == 0) return p ? 2'd0 : 2'd3;
      if (mux == 1)        return 2'd1;
      return p ? 2'd2 : 2'd1;
   endfunction

   // R5: segment codes per mode and lit state
   function automatic logic [1:0] e_seg(int mux, bit lit, bit p);
      if (lit)                  return p ? 2'd3 : 2'd0;
      if (mux == 0 || mux == 1) return p ? 2'd0 : 2'd3;
      return p ? 2'd1 : 2'd2;
   endfunction

   task automatic check_outputs();
      int hl    = HB << m_rate;
      int half  = tcnt / hl;
      bit p     = half[0];
      int ncom  = m_mux + 1;
      int slot  = (half / 2) % ncom;
      int frame = half / (2 * ncom);
      bit boff  = ((frame / BF) % 2) == 1;
      logic [CM*2-1:0]   xc;
      logic [NSEG*2-1:0] xs;
      bit xsync = (slot == 0) && !p;
      for (int k = 0; k < CM; k++)
         xc[k*2 +: 2] = m_on ? e_com(m_mux, slot == k, p) : 2'd0;
      for (int s = 0; s < NSEG; s++) begin
         bit d  = seg_data[s*CM + slot];
         bit bm = seg_blink[s*CM + slot];
         bit lit = d && !(m_blk && boff && bm);
         xs[s*2 +: 2] = m_on ? e_seg(m_mux, lit, p) : 2'd0;
      end
      vectors += 3;
      if (frame_sync !== xsync) begin
         errors++;
         $display("FAIL R10 t=%0d frame_sync actual %0b expected %0b", tcnt, frame_sync, xsync);
      end
      if (com_lvl !== xc) begin
         errors++;
         $display("FAIL %s t=%0d com_lvl actual %h expected %h",
                  m_on ? "R4 R6" : "R9", tcnt, com_lvl, xc);
      end
      if (seg_lvl !== xs) begin
         errors++;
         $display("FAIL %s t=%0d seg_lvl actual %h expected %h",
                  !m_on ? "R9" : (m_blk && boff) ? "R8" : "R5 R7", tcnt, seg_lvl, xs);
      end
   endtask

   task automatic step(bit chk);
      @(posedge clk); #1;
      if (chk) check_outputs();
      tcnt++;
   endtask

   // R3: a write restarts the scan; outputs show position 0 one edge later
   task automatic apply_cfg(int mux, int rate, bit on, bit blk);
      @(negedge clk);
      cfg_mux = 2'(mux); cfg_rate = 2'(rate); cfg_disp_on = on; cfg_blink_en = blk;
      cfg_wr = 1'b1;
      @(posedge clk); #1;
      cfg_wr = 1'b0;
      m_mux = mux; m_rate = rate; m_on = on; m_blk = blk;
      tcnt = 0;
   endtask

   // R1 R2: hold reset low for nlow sampled edges
   task automatic pulse_reset(int nlow, bit takes);
      @(negedge clk);
      rst_in_n = 1'b0;
      repeat (nlow) step(!takes);
      @(negedge clk);
      rst_in_n = 1'b1;
      if (takes) begin
         @(posedge clk); #1;
         m_mux = 0; m_rate = 0; m_on = 0; m_blk = 0;
         tcnt = 0;
      end
   endtask

   task automatic run(int n, bit churn);
      for (int i = 0; i < n; i++) begin
         step(1'b1);
         if (churn && ($urandom_range(0, 7) == 0))   // R7: data changes mid-frame
            for (int b = 0; b < NSEG*CM; b++) seg_data[b] = 1'($urandom_range(0, 1));
      end
   endtask

   function automatic int frame_len(int mux, int rate);
      return 2 * (HB << rate) * (mux + 1);
   endfunction

   initial begin
      #(4 * 190000);
      errors++;
      $display("FAIL watchdog expired, actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd61357));
      repeat (3) @(posedge clk);
      pulse_reset(14, 1'b1);

      // R2: reset state, all codes 0 and display dark
      vectors++;
      if (com_lvl !== '0 || seg_lvl !== '0) begin
         errors++;
         $display("FAIL R2 reset codes actual %h/%h expected 0/0", com_lvl, seg_lvl);
      end
      seg_data = '1;
      run(40, 1'b0);

      // R4 R5 R6 R3: every mode at every rate, fixed patterns
      for (int m = 0; m < 4; m++)
         for (int r = 0; r < 4; r++) begin
            seg_data = (r[0]) ? {NSEG{4'b1010}} : {NSEG{4'b0110}};
            apply_cfg(m, r, 1'b1, 1'b0);
            run(2 * frame_len(m, r) + 3, 1'b0);
         end

      // R1: 11 low edges are ignored, scan carries on unbroken
      apply_cfg(2, 1, 1'b1, 1'b0);
      run(30, 1'b0);
      pulse_reset(11, 1'b0);
      run(60, 1'b0);

      // R1 R2: exactly 12 low edges reset the configuration
      pulse_reset(12, 1'b1);
      run(30, 1'b0);

      // R8: blink gating over several blink turns
      seg_data  = '1;
      seg_blink = {NSEG{4'b0101}};
      apply_cfg(3, 0, 1'b1, 1'b1);
      run(9 * frame_len(3, 0), 1'b0);
      // R8: blink mask ignored when gating is disabled
      apply_cfg(3, 0, 1'b1, 1'b0);
      run(9 * frame_len(3, 0), 1'b0);

      // R9: display off overrides data
      apply_cfg(3, 1, 1'b0, 1'b1);
      run(2 * frame_len(3, 1), 1'b1);

      // random mix
      for (int it = 0; it < 40; it++) begin
         int m = $urandom_range(0, 3);
         int r = $urandom_range(0, 3);
         for (int b = 0; b < NSEG*CM; b++) begin
            seg_data[b]  = 1'($urandom_range(0, 1));
            seg_blink[b] = 1'($urandom_range(0, 1));
         end
         apply_cfg(m, r, $urandom_range(0, 5) != 0, 1'($urandom_range(0, 1)));
         run(((it % 4) == 0) ? 9 * frame_len(m, r) : 2 * frame_len(m, r) + 5, 1'b1);
      end

      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

endmodule